// File: doc/BRIEF.md
# Stage-1 Access Permission Checker

This block decides whether a memory access that has already been translated may go ahead. It receives the permission-related fields of the final translation entry and a description of the access. The entry fields are the two-bit access-permission code, the two execute-never bits and the access flag. The access is described by its kind (load, store or instruction fetch), whether it runs at the user or the kernel level, and whether it is a kernel-level load or store that asks to be checked with user rights. A control bit also marks writable memory as non-executable. The block returns a single allow bit and a fault class. The fault class is either a permission fault or a missing-access-flag fault.

The decision is registered. One cycle after a request is presented with its valid strobe, the result appears with an output strobe. The result stays unchanged until the next request. Fetching the entry, updating the access flag in memory, and the higher privilege levels are handled elsewhere.

Top module: `s1_perm_check`

## Requirements
- R1: At kernel level (`req_kern`=1, no override), permission code 00 and 01 allow load and store, and codes 10 and 11 allow load and fault on store with a permission fault.
- R2: At user level (`req_kern`=0), code 01 allows load and store, code 11 allows load and faults store, and codes 00 and 10 fault both load and store with a permission fault.
- R3: A fetch at user level faults when `xn_user`=1, and a fetch at kernel level faults when `xn_kern`=1. Each bit has no effect on the other level.
- R4: With `wr_no_exec`=1, a fetch at either level faults when the code is 01 (user-writable), and a kernel fetch faults when the code is 00 (kernel-writable). Codes 10 and 11 are not affected.
- R5: When `acc_flag`=0, the result is an access-flag fault (code 2) with allow low, even when the permission check would pass or would also fail.
- R6: A kernel-level load or store with `as_user`=1 is checked with user permissions.
- R7: `as_user` does not affect instruction fetches; a kernel fetch with `as_user`=1 is still checked against `xn_kern` and not `xn_user`.
- R8: `res_valid` is high exactly one cycle after each cycle with `req_valid` high, and `res_allow`/`res_fault` give that request's decision in that same cycle.
- R9: Fault encoding is 0 none, 1 permission, 2 access flag. `res_allow` is 1 exactly when the code is 0. Results hold when no request is presented.
- R10: After reset, `res_valid`, `res_allow` and `res_fault` are 0.
- R11: Access kind encoding is 0 load, 1 store, 2 fetch; code 3 is checked as a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| perm_code | input | 2 | Access-permission code from the entry |
| xn_user | input | 1 | Execute-never for user level |
| xn_kern | input | 1 | Execute-never for kernel level |
| acc_flag | input | 1 | Access flag of the entry |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| req_kern | input | 1 | 1 for kernel level, 0 for user level |
| as_user | input | 1 | Kernel load/store checked with user rights |
| wr_no_exec | input | 1 | Writable memory is execute-never |
| res_valid | output | 1 | Result strobe |
| res_allow | output | 1 | Access allowed |
| res_fault | output | 2 | Fault class |

## Verification
The bench targets these corner cases:
- A cleared access flag combined with a failing permission check. A design with the wrong priority would report a permission fault.
- The override bit on a fetch. A design that applied it to fetches would consult the user execute-never bit.
- The write-implies-no-execute control at kernel level with code 00. A design that only tested user writability would let the fetch through.
- Crossing the two execute-never bits. Swapping them flips the result.
- The unused access kind.
- Output hold after the strobe falls.

// File: rtl/s1_perm_check.sv
module s1_perm_check (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] perm_code,
  input  logic       xn_user,
  input  logic       xn_kern,
  input  logic       acc_flag,
  input  logic [1:0] acc_kind,
  input  logic       req_kern,
  input  logic       as_user,
  input  logic       wr_no_exec,
  output logic       res_valid,
  output logic       res_allow,
  output logic [1:0] res_fault
);
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;
  localparam logic [1:0] FLT_NONE   = 2'd0;
  localparam logic [1:0] FLT_PERM   = 2'd1;
  localparam logic [1:0] FLT_AFLAG  = 2'd2;

  logic is_fetch, is_store, user_rights;
  logic user_rd, user_wr, kern_wr;
  logic data_ok, exec_ok, perm_ok;
  logic [1:0] fault_n;

  assign is_fetch    = (acc_kind == KIND_FETCH);
  assign is_store    = (acc_kind == KIND_STORE);
  assign user_rights = !req_kern || (as_user && !is_fetch);

  assign user_rd = perm_code[0];
  assign user_wr = (perm_code == 2'b01);
  assign kern_wr = !perm_code[1];

  assign data_ok = user_rights ? (is_store ? user_wr : user_rd)
                               : (is_store ? kern_wr : 1'b1);

  assign exec_ok = req_kern ? (!xn_kern && !(wr_no_exec && kern_wr))
                            : (!xn_user && !(wr_no_exec && user_wr));

  assign perm_ok = is_fetch ? exec_ok : data_ok;
  assign fault_n = !acc_flag ? FLT_AFLAG : (perm_ok ? FLT_NONE : FLT_PERM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_allow <= 1'b0;
      res_fault <= FLT_NONE;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_allow <= (fault_n == FLT_NONE);
        res_fault <= fault_n;
      end
    end
  end
endmodule

module s1_perm_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] perm_code,
  input logic       xn_user,
  input logic       xn_kern,
  input logic       acc_flag,
  input logic [1:0] acc_kind,
  input logic       req_kern,
  input logic       as_user,
  input logic       wr_no_exec,
  input logic       res_valid,
  input logic       res_allow,
  input logic [1:0] res_fault
);
  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid); // R8
  AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(res_allow) && $stable(res_fault)); // R9
  AST_ALLOW_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_allow == (res_fault == 2'd0)) && (res_fault != 2'd3)); // R9
  AST_AFLAG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !acc_flag |=> res_fault == 2'd2 && !res_allow); // R5
  AST_USER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && acc_flag && acc_kind == 2'd1 && perm_code != 2'b01 &&
    (!req_kern || as_user) |=> res_fault == 2'd1); // R2
  AST_XN_USER: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && acc_flag && acc_kind == 2'd2 && !req_kern && xn_user
    |=> res_fault == 2'd1); // R3
  AST_XN_KERN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && acc_flag && acc_kind == 2'd2 && req_kern && xn_kern
    |=> res_fault == 2'd1); // R3
  AST_WXN_USER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && acc_flag && acc_kind == 2'd2 && wr_no_exec && perm_code == 2'b01
    |=> !res_allow); // R4
  AST_KERN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && acc_flag && acc_kind == 2'd0 && req_kern && !as_user
    |=> res_allow); // R1
endmodule

bind s1_perm_check s1_perm_check_sva u_sva (.*);

// File: tb/s1_perm_check_test.sv
module s1_perm_check_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] perm_code = 2'd0;
  logic xn_user = 1'b0, xn_kern = 1'b0, acc_flag = 1'b0;
  logic [1:0] acc_kind = 2'd0;
  logic req_kern = 1'b0, as_user = 1'b0, wr_no_exec = 1'b0;
  logic res_valid, res_allow;
  logic [1:0] res_fault;
  int n_checks = 0;
  int n_fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  s1_perm_check uut (.*);

  // {code, xn_user, xn_kern, flag, kind, kern, as_user, wxn, req, allow, fault}
  localparam int NV = 28;
  localparam logic [16:0] VEC [NV] = '{
    {2'b00,1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,1'b0,4'd1,1'b1,2'd0}, // R1
    {2'b00,1'b0,1'b0,1'b1,2'd1,1'b1,1'b0,1'b0,4'd1,1'b1,2'd0}, // R1
    {2'b10,1'b0,1'b0,1'b1,2'd1,1'b1,1'b0,1'b0,4'd1,1'b0,2'd1}, // R1
    {2'b10,1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,1'b0,4'd1,1'b1,2'd0}, // R1
    {2'b11,1'b0,1'b0,1'b1,2'd1,1'b1,1'b0,1'b0,4'd1,1'b0,2'd1}, // R1
    {2'b00,1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,4'd2,1'b0,2'd1}, // R2
    {2'b01,1'b0,1'b0,1'b1,2'd1,1'b0,1'b0,1'b0,4'd2,1'b1,2'd0}, // R2
    {2'b11,1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,4'd2,1'b1,2'd0}, // R2
    {2'b11,1'b0,1'b0,1'b1,2'd1,1'b0,1'b0,1'b0,4'd2,1'b0,2'd1}, // R2
    {2'b10,1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,4'd2,1'b0,2'd1}, // R2
    {2'b11,1'b1,1'b0,1'b1,2'd2,1'b0,1'b0,1'b0,4'd3,1'b0,2'd1}, // R3
    {2'b11,1'b0,1'b1,1'b1,2'd2,1'b0,1'b0,1'b0,4'd3,1'b1,2'd0}, // R3
    {2'b11,1'b0,1'b1,1'b1,2'd2,1'b1,1'b0,1'b0,4'd3,1'b0,2'd1}, // R3
    {2'b11,1'b1,1'b0,1'b1,2'd2,1'b1,1'b0,1'b0,4'd3,1'b1,2'd0}, // R3
    {2'b01,1'b0,1'b0,1'b1,2'd2,1'b0,1'b0,1'b1,4'd4,1'b0,2'd1}, // R4
    {2'b01,1'b0,1'b0,1'b1,2'd2,1'b1,1'b0,1'b1,4'd4,1'b0,2'd1}, // R4
    {2'b00,1'b0,1'b0,1'b1,2'd2,1'b1,1'b0,1'b1,4'd4,1'b0,2'd1}, // R4
    {2'b11,1'b0,1'b0,1'b1,2'd2,1'b0,1'b0,1'b1,4'd4,1'b1,2'd0}, // R4
    {2'b10,1'b0,1'b0,1'b1,2'd2,1'b1,1'b0,1'b1,4'd4,1'b1,2'd0}, // R4
    {2'b01,1'b0,1'b0,1'b0,2'd1,1'b1,1'b0,1'b0,4'd5,1'b0,2'd2}, // R5
    {2'b10,1'b0,1'b0,1'b0,2'd1,1'b1,1'b0,1'b0,4'd5,1'b0,2'd2}, // R5
    {2'b00,1'b0,1'b0,1'b1,2'd0,1'b1,1'b1,1'b0,4'd6,1'b0,2'd1}, // R6
    {2'b01,1'b0,1'b0,1'b1,2'd1,1'b1,1'b1,1'b0,4'd6,1'b1,2'd0}, // R6
    {2'b00,1'b0,1'b0,1'b1,2'd1,1'b1,1'b1,1'b0,4'd6,1'b0,2'd1}, // R6
    {2'b00,1'b1,1'b0,1'b1,2'd2,1'b1,1'b1,1'b0,4'd7,1'b1,2'd0}, // R7
    {2'b11,1'b0,1'b1,1'b1,2'd2,1'b1,1'b1,1'b0,4'd7,1'b0,2'd1}, // R7
    {2'b00,1'b0,1'b0,1'b1,2'd3,1'b0,1'b0,1'b0,4'd11,1'b0,2'd1}, // R11
    {2'b11,1'b0,1'b0,1'b1,2'd3,1'b0,1'b0,1'b0,4'd11,1'b1,2'd0}  // R11
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [16:0] v);
    @(negedge clk);
    {perm_code, xn_user, xn_kern, acc_flag, acc_kind, req_kern, as_user, wr_no_exec} = v[16:7];
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R10 reset", {res_valid, res_allow, res_fault}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle strobe", {3'b0, res_valid}, 4'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      check($sformatf("R%0d vec%0d", VEC[i][6:3], i),
            {res_valid, res_allow, res_fault}, {1'b1, VEC[i][2:0]});
    end

    // R9: hold with no request, inputs changed to an allowing pattern
    drive({2'b01,1'b0,1'b0,1'b0,2'd0,1'b1,1'b0,1'b0,4'd5,1'b0,2'd2});
    perm_code = 2'b01; acc_flag = 1'b1; acc_kind = 2'd0;
    @(negedge clk);
    check("R9 hold", {res_valid, res_allow, res_fault}, 4'b0010);
    check("R8 strobe drops", {3'b0, res_valid}, 4'd0);

    // R8: back-to-back requests each give their own result
    @(negedge clk);
    {perm_code, xn_user, xn_kern, acc_flag, acc_kind, req_kern, as_user, wr_no_exec} =
      {2'b11,1'b0,1'b0,1'b1,2'd1,1'b0,1'b0,1'b0};
    req_valid = 1'b1;
    @(negedge clk);
    check("R8 b2b first", {res_valid, res_allow, res_fault}, 4'b1001);
    acc_kind = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 b2b second", {res_valid, res_allow, res_fault}, 4'b1100);

    // R10: reset mid-run clears results
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 re-reset", {res_valid, res_allow, res_fault}, 4'b0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule